// File: doc/BRIEF.md
# Table-Driven Serial Flash Command Sequencer

This block runs serial flash transactions from a small program kept on chip. Software loads a table of 32-bit words. Each group of four words is one sequence, and each word holds two 16-bit instructions. The instructions send a command byte, send an address, insert idle clock cycles, read data bytes or write data bytes. A single write to the command register picks a sequence and sets the data byte count. The engine then asserts chip select, steps through the instructions on one data line (clock idles low, data is driven while the clock is low and sampled on the rising clock edge), and releases chip select when the sequence ends.

Write data enters on a valid/ready word stream into a transmit FIFO. A transfer takes place in any cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` falls only while the FIFO is full. Read data leaves on a valid/ready word stream from a receive FIFO. `rx_valid` stays high and `rx_data` stays stable until `rx_ready` is seen. If the transmit FIFO runs dry, or the receive FIFO has no room, the engine holds the serial clock low until the stream catches up.

The table is locked after reset. A key write must come directly before a lock-control write.

Top module: `flash_seq_ctrl`

## Requirements
- R1: The table holds 64 words at configuration word addresses 0..63, and sequence s occupies words 4s..4s+3. Each word holds two instructions, and the one in bits 15:0 runs before the one in bits 31:16. Within an instruction, bits 15:10 are the opcode, bits 9:8 the line code and bits 7:0 the argument.
- R2: Opcode 1 shifts the argument byte out on `flash_mosi`, most significant bit first.
- R3: Opcode 2 shifts out the low N bits of the address register (configuration address 65), most significant bit first, where N is the argument (24 or 32).
- R4: Opcode 3 produces N serial clock cycles with `flash_mosi` low, where N is the argument. An argument of 0 produces no cycles.
- R5: Opcode 7 reads count bytes. The bytes are packed little-endian into 32-bit words on the rx stream, and a final partial word is zero-filled. `rx_level` gives the number of words held, at most 32.
- R6: Opcode 8 sends count bytes taken from tx words. Each word gives its bytes in order 7:0, 15:8, 23:16, 31:24, and each byte goes out most significant bit first. If no word is available, the serial clock stops with chip select held until data arrives.
- R7: A write to the command register (configuration address 64) starts sequence wdata[27:24] with count wdata[7:0]. With a count of 0, read and write steps produce no clock cycles.
- R8: A sequence ends at an instruction with opcode 0, an unknown opcode or a nonzero line code, or after the eighth instruction. `flash_cs_n` is low only while the sequence runs, and `flash_sck` is low whenever `flash_cs_n` is high.
- R9: `busy` goes high on the cycle after a command write and stays high until the sequence ends. A command write made while `busy` is high is ignored.
- R10: The table is locked after reset, and table writes made while it is locked change nothing.
- R11: A lock-control write (address 67) with 1 locks the table and with 2 unlocks it. Either takes effect only if the configuration write just before it wrote 0x5AF05AF0 to the key register (address 66).
- R12: A write to the control register (address 68) with bit 10 set empties the receive FIFO. With bit 11 set, it empties the transmit FIFO.
- R13: When the receive FIFO is full, the engine stops the serial clock before the next read byte and resumes once a word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit FIFO can accept a word |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Receive word available |
| rx_ready | input | 1 | Consumer takes the receive word |
| rx_data | output | 32 | Receive word |
| busy | output | 1 | Sequence in progress |
| locked | output | 1 | Table write protection active |
| rx_level | output | 6 | Receive FIFO fill in words |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Serial data to flash |
| flash_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume configuration writes are single-cycle strobes with a defined address. They also assume the flash data input is stable around the rising edges of the serial clock, so that chip select and clock relations depend only on the engine. The stimulus drives all inputs at falling clock edges and gives the flash model new data only after a serial clock fall. Random sequences keep address widths at 24 or 32, idle cycles at ten or fewer and byte counts within the receive FIFO, while directed cases push beyond it to exercise back-pressure.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_WRITE = 6'd8;

  localparam logic [6:0] REG_CMD  = 7'd64;
  localparam logic [6:0] REG_ADDR = 7'd65;
  localparam logic [6:0] REG_KEY  = 7'd66;
  localparam logic [6:0] REG_LOCK = 7'd67;
  localparam logic [6:0] REG_CTRL = 7'd68;

  localparam logic [31:0] UNLOCK_KEY = 32'h5AF0_5AF0;
  localparam int CTRL_FLUSH_RX = 10;
  localparam int CTRL_FLUSH_TX = 11;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] lines;
    logic [7:0] arg;
  } instr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_DONE} seq_state_e;
endpackage

// File: rtl/fsq_lut.sv
module fsq_lut
  import flash_seq_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [6:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word,
  output logic             locked
);
  logic [31:0] tbl [WORDS];
  logic        key_armed;

  assign rd_word = tbl[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      key_armed <= 1'b0;
      for (int i = 0; i < WORDS; i++) tbl[i] <= '0;
    end else if (cfg_we) begin
      key_armed <= (cfg_addr == REG_KEY) && (cfg_wdata == UNLOCK_KEY);
      if (cfg_addr == REG_LOCK && key_armed) begin
        if (cfg_wdata == 32'd1) locked <= 1'b1;
        else if (cfg_wdata == 32'd2) locked <= 1'b0;
      end
      if (!locked && (int'(cfg_addr) < WORDS)) tbl[cfg_addr[IDX_W-1:0]] <= cfg_wdata;
    end
  end
endmodule

// File: rtl/fsq_fifo.sv
module fsq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign empty    = (level == '0);
  assign do_push  = push && (level != LW'(DEPTH));
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) if (do_push) mem[wptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0;
    end else if (flush) begin
      wptr <= '0; rptr <= '0; level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/fsq_engine.sv
module fsq_engine
  import flash_seq_pkg::*;
#(
  parameter int SEQ_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEQ_W-1:0] start_seq,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [31:0]      flash_addr,
  output logic [SEQ_W+1:0] tbl_idx,
  input  logic [31:0]      tbl_word,
  input  logic [31:0]      tx_word,
  input  logic             tx_empty,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [31:0]      rx_word,
  output logic             busy,
  output logic             cs_n,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  seq_state_e       st;
  logic [SEQ_W-1:0] seq;
  logic [2:0]       ip;
  logic [5:0]       kind;
  logic [31:0]      shreg, acc;
  logic [7:0]       bits;
  logic [CNT_W-1:0] cnt, left;
  logic [1:0]       bsel;
  logic             need_byte, half, sck_q;
  instr_t           ins;
  logic             last_ip, byte_done, is_data, word_end;
  logic [7:0]       tx_byte;

  assign tbl_idx   = {seq, ip[2:1]};
  assign ins       = ip[0] ? tbl_word[31:16] : tbl_word[15:0];
  assign last_ip   = (ip == 3'd7);
  assign is_data   = (kind == OP_READ) || (kind == OP_WRITE);
  assign byte_done = (st == ST_SHIFT) && !need_byte && half && (bits == 8'd1);
  assign word_end  = (bsel == 2'd3) || (left == CNT_W'(1));
  assign rx_word   = acc | (32'(shreg[7:0]) << {bsel, 3'b000});
  assign rx_push   = byte_done && (kind == OP_READ) && word_end;
  assign tx_pop    = byte_done && (kind == OP_WRITE) && word_end;
  assign tx_byte   = 8'(tx_word >> {bsel, 3'b000});
  assign busy      = (st != ST_IDLE);
  assign cs_n      = (st == ST_IDLE) || (st == ST_DONE);
  assign sck       = sck_q;
  assign mosi      = (st == ST_SHIFT) && !need_byte &&
                     (kind == OP_CMD || kind == OP_ADDR || kind == OP_WRITE) && shreg[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; seq <= '0; ip <= '0; kind <= OP_STOP; shreg <= '0; acc <= '0;
      bits <= '0; cnt <= '0; left <= '0; bsel <= '0; need_byte <= 1'b0;
      half <= 1'b0; sck_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          seq <= start_seq; cnt <= start_cnt; ip <= '0; st <= ST_LOAD;
        end
        ST_LOAD: begin
          kind <= ins.op; half <= 1'b0; need_byte <= 1'b0; bsel <= '0; acc <= '0;
          if (ins.lines != 2'd0) st <= ST_DONE;
          else case (ins.op)
            OP_CMD: begin
              shreg <= {ins.arg, 24'b0}; bits <= 8'd8; st <= ST_SHIFT;
            end
            OP_ADDR, OP_DUMMY: begin
              shreg <= (ins.op == OP_ADDR) ? (flash_addr << (8'd32 - ins.arg)) : '0;
              bits  <= ins.arg;
              if (ins.arg != 8'd0) st <= ST_SHIFT;
              else if (last_ip) st <= ST_DONE;
              else ip <= ip + 3'd1;
            end
            OP_READ, OP_WRITE: begin
              left <= cnt; bits <= 8'd8; need_byte <= 1'b1;
              if (cnt != '0) st <= ST_SHIFT;
              else if (last_ip) st <= ST_DONE;
              else ip <= ip + 3'd1;
            end
            default: st <= ST_DONE;
          endcase
        end
        ST_SHIFT: begin
          if (need_byte) begin
            if (kind == OP_WRITE && !tx_empty) begin
              shreg <= {tx_byte, 24'b0}; need_byte <= 1'b0;
            end else if (kind == OP_READ && !rx_full) begin
              need_byte <= 1'b0;
            end
          end else if (!half) begin
            sck_q <= 1'b1; half <= 1'b1;
            if (kind == OP_READ) shreg <= {shreg[30:0], miso};
          end else begin
            sck_q <= 1'b0; half <= 1'b0; bits <= bits - 8'd1;
            if (kind != OP_READ) shreg <= shreg << 1;
            if (bits == 8'd1) begin
              if (is_data) begin
                if (kind == OP_READ) acc <= (bsel == 2'd3) ? '0 : rx_word;
                bsel <= bsel + 2'd1;
                left <= left - CNT_W'(1);
                bits <= 8'd8;
                need_byte <= 1'b1;
              end
              if (!is_data || left == CNT_W'(1)) begin
                if (last_ip) st <= ST_DONE;
                else begin ip <= ip + 3'd1; st <= ST_LOAD; end
              end
            end
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int TBL_WORDS = 64,
  parameter int RX_BYTES  = 128,
  parameter int TX_BYTES  = 64,
  parameter int CNT_W     = 8,
  localparam int SEQ_W    = $clog2(TBL_WORDS / 4),
  localparam int RX_WORDS = RX_BYTES / 4,
  localparam int TX_WORDS = TX_BYTES / 4,
  localparam int RXL_W    = $clog2(RX_WORDS + 1),
  localparam int TXL_W    = $clog2(TX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [6:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [31:0]      tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [31:0]      rx_data,
  output logic             busy,
  output logic             locked,
  output logic [RXL_W-1:0] rx_level,
  output logic             flash_cs_n,
  output logic             flash_sck,
  output logic             flash_mosi,
  input  logic             flash_miso
);
  logic [31:0]      flash_addr, tbl_word, tx_word, rx_word;
  logic [SEQ_W+1:0] tbl_idx;
  logic             tx_empty, tx_pop, rx_empty, rx_push, rx_full;
  logic             ctrl_wr, flush_rx, flush_tx, start;
  logic [TXL_W-1:0] tx_level;

  assign ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
  assign flush_rx = ctrl_wr && cfg_wdata[CTRL_FLUSH_RX];
  assign flush_tx = ctrl_wr && cfg_wdata[CTRL_FLUSH_TX];
  assign start    = cfg_we && (cfg_addr == REG_CMD);
  assign tx_ready = (tx_level != TXL_W'(TX_WORDS));
  assign rx_full  = (rx_level == RXL_W'(RX_WORDS));
  assign rx_valid = !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flash_addr <= '0;
    else if (cfg_we && cfg_addr == REG_ADDR) flash_addr <= cfg_wdata;
  end

  fsq_lut #(.WORDS(TBL_WORDS)) u_lut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .rd_idx(tbl_idx), .rd_word(tbl_word), .locked
  );

  fsq_fifo #(.W(32), .DEPTH(TX_WORDS)) u_txq (
    .clk, .rst_n, .flush(flush_tx), .push(tx_valid && tx_ready), .push_data(tx_data),
    .pop(tx_pop), .pop_data(tx_word), .empty(tx_empty), .level(tx_level)
  );

  fsq_fifo #(.W(32), .DEPTH(RX_WORDS)) u_rxq (
    .clk, .rst_n, .flush(flush_rx), .push(rx_push), .push_data(rx_word),
    .pop(rx_ready), .pop_data(rx_data), .empty(rx_empty), .level(rx_level)
  );

  fsq_engine #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_eng (
    .clk, .rst_n, .start,
    .start_seq(cfg_wdata[24 +: SEQ_W]), .start_cnt(cfg_wdata[CNT_W-1:0]),
    .flash_addr, .tbl_idx, .tbl_word, .tx_word, .tx_empty, .tx_pop,
    .rx_full, .rx_push, .rx_word, .busy,
    .cs_n(flash_cs_n), .sck(flash_sck), .mosi(flash_mosi), .miso(flash_miso)
  );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker
  import flash_seq_pkg::*;
#(
  parameter int RX_WORDS = 32,
  localparam int RXL_W = $clog2(RX_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [6:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic             busy,
  input logic             locked,
  input logic [RXL_W-1:0] rx_level,
  input logic             flash_cs_n,
  input logic             flash_sck
);
  logic key_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_prev <= 1'b0;
    else if (cfg_we) key_prev <= (cfg_addr == REG_KEY) && (cfg_wdata == UNLOCK_KEY);
  end

  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_cs_n |-> busy); // R8
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> !flash_sck); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_CMD) |=> busy); // R9
  AST_LOCK_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(cfg_we && cfg_addr == REG_LOCK && key_prev)); // R11
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= RXL_W'(RX_WORDS)); // R5
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == REG_CTRL && cfg_wdata[CTRL_FLUSH_RX]) |=> (rx_level == '0)); // R12
endmodule

bind flash_seq_ctrl fsq_checker #(.RX_WORDS(RX_BYTES / 4)) u_fsq_checker (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .busy(busy), .locked(locked), .rx_level(rx_level),
  .flash_cs_n(flash_cs_n), .flash_sck(flash_sck)
);

// File: tb/test_flash_seq_ctrl.sv
`timescale 1ns/1ps
module test_flash_seq_ctrl;
  import flash_seq_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cfg_we, tx_valid, tx_ready, rx_valid, rx_ready, busy, locked;
  logic flash_cs_n, flash_sck, flash_mosi, flash_miso;
  logic [6:0] cfg_addr;
  logic [31:0] cfg_wdata, tx_data, rx_data;
  logic [5:0] rx_level;

  flash_seq_ctrl i_flash_seq_ctrl (.*);

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash model: logs mosi bits per select, supplies a known bit pattern
  bit mlog [8192];
  int nb = 0, cs_falls = 0;

  function automatic logic [7:0] pat(int k);
    return 8'(k * 29 + (k >> 2) + 92);
  endfunction
  function automatic logic gbit(int j);
    logic [7:0] p;
    p = pat(j / 8);
    return p[3'(7 - (j % 8))];
  endfunction
  function automatic logic [31:0] mfield(int off, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[30:0], mlog[off + i]};
    return v;
  endfunction
  function automatic logic [7:0] expbyte(int off);
    logic [7:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[6:0], gbit(off + i)};
    return v;
  endfunction
  function automatic logic [15:0] ins(logic [5:0] op, logic [7:0] arg);
    return {op, 2'b00, arg};
  endfunction

  always @(negedge flash_cs_n) begin nb = 0; cs_falls++; flash_miso = gbit(0); end
  always @(posedge flash_sck) if (!flash_cs_n) begin
    if (nb < 8192) mlog[nb] = flash_mosi;
    nb++;
  end
  always @(negedge flash_sck) if (!flash_cs_n) flash_miso = gbit(nb);

  task automatic cfg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic put_seq(input int s, input logic [31:0] w0, w1, w2, w3);
    cfg(7'(4*s), w0); cfg(7'(4*s+1), w1); cfg(7'(4*s+2), w2); cfg(7'(4*s+3), w3);
  endtask
  task automatic start(input int s, input int c);
    cfg(REG_CMD, {4'b0, 4'(s), 16'b0, 8'(c)});
  endtask
  task automatic wait_idle();
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
  endtask
  task automatic run(input int s, input int c);
    start(s, c); wait_idle();
  endtask
  task automatic tx_push(input logic [31:0] w);
    @(negedge clk); tx_valid = 1; tx_data = w;
    @(negedge clk); tx_valid = 0;
  endtask
  task automatic rx_pop(output logic [31:0] w, output bit ok);
    int t = 0;
    @(negedge clk);
    while (!rx_valid && t < 3000) begin @(negedge clk); t++; end
    ok = rx_valid; w = rx_data; rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask
  task automatic check_read(input int off, input int cnt, input string req);
    for (int w = 0; w < (cnt + 3) / 4; w++) begin
      logic [31:0] got, exp;
      bit ok;
      exp = '0;
      for (int b = 0; b < 4; b++)
        if (4*w + b < cnt) exp[8*b +: 8] = expbyte(off + 8*(4*w + b));
      rx_pop(got, ok);
      chk(ok && got == exp, req, "read word", got, exp);
    end
  endtask
  task automatic check_write(input int off, input logic [31:0] words [4], input int cnt, input string req);
    for (int i = 0; i < cnt; i++) begin
      logic [7:0] e;
      e = words[i/4][8*(i%4) +: 8];
      chk(mfield(off + 8*i, 8) == 32'(e), req, "sent byte", mfield(off + 8*i, 8), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] wl [4];
    int n1, s0;
    void'($urandom(32'd4242));
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    tx_valid = 0; tx_data = '0; rx_ready = 0; flash_miso = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && flash_cs_n && !flash_sck && rx_level == 0 && !rx_valid, "R9", "reset idle",
        {busy, flash_cs_n, flash_sck}, 3'b010);
    chk(locked, "R10", "locked at reset", locked, 1);

    // R10: writes while locked are dropped; empty sequence clocks nothing
    put_seq(1, {ins(OP_READ, 0), ins(OP_CMD, 8'h9F)}, 0, 0, 0);
    run(1, 0);
    chk(nb == 0, "R10", "locked table write ignored", nb, 0);

    // R11: key sequencing
    cfg(REG_LOCK, 2);
    chk(locked, "R11", "unlock without key", locked, 1);
    cfg(REG_KEY, UNLOCK_KEY); cfg(REG_ADDR, 0); cfg(REG_LOCK, 2);
    chk(locked, "R11", "key not adjacent", locked, 1);
    cfg(REG_KEY, 32'h1234_5678); cfg(REG_LOCK, 2);
    chk(locked, "R11", "wrong key", locked, 1);
    cfg(REG_KEY, UNLOCK_KEY); cfg(REG_LOCK, 2);
    chk(!locked, "R11", "keyed unlock", locked, 0);

    // R2 R5: command then short read
    put_seq(1, {ins(OP_READ, 0), ins(OP_CMD, 8'h9F)}, 0, 0, 0);
    run(1, 3);
    chk(nb == 32, "R5", "read clock count", nb, 32);
    chk(mfield(0, 8) == 32'h9F, "R2", "command byte", mfield(0, 8), 8'h9F);
    check_read(8, 3, "R5");
    chk(!rx_valid, "R5", "rx empty after drain", rx_valid, 0);

    // R7: zero count skips read
    run(1, 0);
    chk(nb == 8 && !rx_valid, "R7", "zero count", nb, 8);

    // R10 R11: lock again, write ignored
    cfg(REG_KEY, UNLOCK_KEY); cfg(REG_LOCK, 1);
    chk(locked, "R11", "keyed lock", locked, 1);
    put_seq(1, {16'b0, ins(OP_CMD, 8'h11)}, 0, 0, 0);
    run(1, 0);
    chk(mfield(0, 8) == 32'h9F, "R10", "table kept while locked", mfield(0, 8), 8'h9F);
    cfg(REG_KEY, UNLOCK_KEY); cfg(REG_LOCK, 2);

    // R1 R2 R3 R4 R5: random read sequences
    for (int it = 0; it < 8; it++) begin
      int s, dm, c, ab;
      logic [7:0] cmd;
      logic [31:0] ad, am;
      s = $urandom % 16; dm = $urandom % 11; c = 1 + $urandom % 40;
      ab = ($urandom % 2) ? 32 : 24; cmd = 8'($urandom); ad = $urandom;
      am = (ab == 32) ? ad : {8'b0, ad[23:0]};
      cfg(REG_ADDR, ad);
      put_seq(s, {ins(OP_ADDR, 8'(ab)), ins(OP_CMD, cmd)},
                 {ins(OP_READ, 0), ins(OP_DUMMY, 8'(dm))}, 0, 0);
      run(s, c);
      chk(nb == 8 + ab + dm + 8*c, "R1", "sequence clock count", nb, 8 + ab + dm + 8*c);
      chk(mfield(0, 8) == 32'(cmd), "R2", "random command", mfield(0, 8), cmd);
      chk(mfield(8, ab) == am, "R3", "address bits", mfield(8, ab), am);
      if (dm > 0) chk(mfield(8 + ab, dm) == 0, "R4", "dummy low", mfield(8 + ab, dm), 0);
      check_read(8 + ab + dm, c, "R5");
    end

    // R8: eight instructions then stop; unknown opcode; nonzero line code
    put_seq(15, {ins(OP_CMD, 8'hA1), ins(OP_CMD, 8'hA0)}, {ins(OP_CMD, 8'hA3), ins(OP_CMD, 8'hA2)},
                {ins(OP_CMD, 8'hA5), ins(OP_CMD, 8'hA4)}, {ins(OP_CMD, 8'hA7), ins(OP_CMD, 8'hA6)});
    run(15, 0);
    chk(nb == 64 && mfield(56, 8) == 32'hA7, "R8", "eight instructions", nb, 64);
    put_seq(3, {ins(6'd5, 8'h00), ins(OP_CMD, 8'h33)}, {16'b0, ins(OP_CMD, 8'h44)}, 0, 0);
    run(3, 0);
    chk(nb == 8, "R8", "unknown opcode ends", nb, 8);
    put_seq(4, {16'h0655, ins(OP_CMD, 8'h66)}, {16'b0, ins(OP_CMD, 8'h77)}, 0, 0);
    run(4, 0);
    chk(nb == 8, "R8", "line code ends", nb, 8);
    chk(flash_cs_n && !flash_sck, "R8", "idle after end", {flash_cs_n, flash_sck}, 2'b10);

    // R6: write step
    cfg(REG_ADDR, 32'h00AB_CDEF);
    put_seq(2, {ins(OP_ADDR, 24), ins(OP_CMD, 8'h02)}, {16'b0, ins(OP_WRITE, 0)}, 0, 0);
    wl[0] = $urandom; wl[1] = $urandom; wl[2] = 0; wl[3] = 0;
    tx_push(wl[0]); tx_push(wl[1]);
    run(2, 6);
    chk(nb == 80, "R6", "write clock count", nb, 80);
    chk(mfield(8, 24) == 32'hABCDEF, "R3", "write address", mfield(8, 24), 32'hABCDEF);
    check_write(32, wl, 6, "R6");

    // R6 R9: underrun stall, command while busy ignored
    wl[0] = $urandom; wl[1] = $urandom;
    tx_push(wl[0]);
    start(2, 8);
    repeat (300) @(negedge clk);
    chk(busy && nb == 64, "R6", "underrun stall", nb, 64);
    s0 = cs_falls;
    start(1, 0);
    tx_push(wl[1]);
    wait_idle();
    chk(cs_falls == s0 && nb == 96, "R9", "busy command ignored", nb, 96);
    check_write(32, wl, 8, "R6");

    // R12: transmit flush
    tx_push(32'hDEAD_BEEF); tx_push(32'hCAFE_F00D);
    cfg(REG_CTRL, 32'h800);
    wl[0] = $urandom;
    start(2, 4);
    tx_push(wl[0]);
    wait_idle();
    chk(nb == 64, "R12", "tx flush count", nb, 64);
    check_write(32, wl, 4, "R12");

    // R12: receive flush
    put_seq(1, {ins(OP_READ, 0), ins(OP_CMD, 8'h9F)}, 0, 0, 0);
    run(1, 8);
    chk(rx_level == 2, "R5", "rx level words", rx_level, 2);
    cfg(REG_CTRL, 32'h400);
    chk(rx_level == 0 && !rx_valid, "R12", "rx flush", rx_level, 0);

    // R13: receive back-pressure
    start(1, 140);
    begin
      int t = 0;
      while (rx_level != 32 && t < 20000) begin @(negedge clk); t++; end
    end
    repeat (100) @(negedge clk);
    n1 = nb;
    repeat (50) @(negedge clk);
    chk(busy && rx_level == 32 && nb == n1 && nb == 1032, "R13", "stall when full", nb, 1032);
    check_read(8, 140, "R13");
    wait_idle();
    chk(nb == 1128 && !busy, "R13", "resume after drain", nb, 1128);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule